// File: doc/BRIEF.md
# Dual-View Floating-Point Register File

This block holds the floating-point register state of a processor core: sixty-four-bit storage entries seen through a 32-bit single-precision view and a 64-bit double-precision view. A mode input picks how register numbers land on storage. In paired mode (`fr_mode` = 0), two consecutive single registers share one entry and a double register names the entry holding its pair. In wide mode (`fr_mode` = 1), every register number owns a whole entry and a single register uses only the low half of that entry.

Each view has one combinational read port and one write port that takes effect at the next rising clock. A small control space sits beside the data storage. It holds a read-only revision word at index 0 and a writable control/status word at the top index. The rounding mode is taken from the two lowest bits of that control/status word.

The ports accept an access every cycle and never stall. They have no valid/ready pair because a register file has nothing to apply back-pressure to. A write strobe marks a write, and a read port presents data for whatever index is on its pins.

Top module: `fpr_file`

## Requirements
- R1: While `rst_n` is low, and after reset releases, every storage entry reads zero, the control/status word reads zero and `round_mode` is 2'b00 (nearest).
- R2: With `fr_mode` = 0, single register n reads entry n>>1. It takes bits 31:0 when n is even and bits 63:32 when n is odd.
- R3: With `fr_mode` = 0, double register n reads and writes the whole of entry n>>1, so registers 2k and 2k+1 reach the same 64 bits.
- R4: With `fr_mode` = 1, double register n is entry n, and single register n is bits 31:0 of entry n.
- R5: A single-precision write replaces only its mapped 32-bit half. The other half of that entry keeps its value.
- R6: A single write and a double write that reach the same entry in the same cycle merge. The single write's half comes from the single data and the other half comes from the double data.
- R7: The mapping follows the current `fr_mode` on every access. Changing the mode alters no stored bit, and the next access uses the new mapping.
- R8: A read in the same cycle as a write to the same storage returns the value held before that write. The new value is readable from the next cycle.
- R9: Control index 0 reads the REVISION parameter, and writes to it are ignored. Index 2**CTRL_IDX_W-1 reads back the last value written to it. Every other control index reads zero and ignores writes.
- R10: `round_mode` equals bits 1:0 of the control/status word from the cycle after that word is written. The encoding is 00 nearest, 01 toward zero, 10 toward +infinity and 11 toward -infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_mode | input | 1 | 0 = paired mapping, 1 = wide mapping |
| s_rd_idx | input | 5 | Single-view read register number |
| s_rd_data | output | 32 | Single-view read data |
| d_rd_idx | input | 5 | Double-view read register number |
| d_rd_data | output | 64 | Double-view read data |
| s_we | input | 1 | Single-view write strobe |
| s_wr_idx | input | 5 | Single-view write register number |
| s_wr_data | input | 32 | Single-view write data |
| d_we | input | 1 | Double-view write strobe |
| d_wr_idx | input | 5 | Double-view write register number |
| d_wr_data | input | 64 | Double-view write data |
| ctl_rd_idx | input | 5 | Control-space read index |
| ctl_rd_data | output | 32 | Control-space read data |
| ctl_we | input | 1 | Control-space write strobe |
| ctl_wr_idx | input | 5 | Control-space write index |
| ctl_wr_data | input | 32 | Control-space write data |
| round_mode | output | 2 | Current rounding mode |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a single-view write and a double-view write landing on one entry. The second is a read landing on storage that a write is updating in that cycle. The random phase draws register numbers from a narrow range and toggles the mode now and then, so both pairs of events happen often. Directed steps also force each one on purpose. A bench model applies the double write first and the single write over it, then compares every read against the model as it stood before the clock edge. This confirms both the merge rule and read-before-write.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  // Rounding-mode encoding held in the low bits of the control/status word
  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_POS_INF = 2'b10,
    RND_NEG_INF = 2'b11
  } rnd_mode_e;

  // Bit position of the rounding field inside the control/status word
  localparam int unsigned RM_LSB = 0;

endpackage

// File: rtl/fpr_slot_map.sv
// Maps a single-view register number onto an entry and a half.
module fpr_slot_map #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             fr_mode,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] entry,
  output logic             upper
);

  always_comb begin
    if (fr_mode) begin
      entry = idx;
      upper = 1'b0;
    end else begin
      entry = {1'b0, idx[IDX_W-1:1]};
      upper = idx[0];
    end
  end

endmodule

// File: rtl/fpr_storage.sv
// Entry array kept as separate low and high halves, so a single write
// touches one half and a double write touches both.
module fpr_storage #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_we,
  input  logic [IDX_W-1:0]    s_wr_entry,
  input  logic                s_wr_upper,
  input  logic [HALF_W-1:0]   s_wr_data,
  input  logic                d_we,
  input  logic [IDX_W-1:0]    d_wr_entry,
  input  logic [2*HALF_W-1:0] d_wr_data,
  input  logic [IDX_W-1:0]    s_rd_entry,
  input  logic                s_rd_upper,
  output logic [HALF_W-1:0]   s_rd_data,
  input  logic [IDX_W-1:0]    d_rd_entry,
  output logic [2*HALF_W-1:0] d_rd_data
);

  logic [HALF_W-1:0] lo_q [ENTRIES];
  logic [HALF_W-1:0] hi_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              hit_d;
    logic              hit_s_lo;
    logic              hit_s_hi;
    logic [HALF_W-1:0] lo_r;
    logic [HALF_W-1:0] hi_r;

    assign hit_d    = d_we && (d_wr_entry == IDX_W'(e));
    assign hit_s_lo = s_we && (s_wr_entry == IDX_W'(e)) && !s_wr_upper;
    assign hit_s_hi = s_we && (s_wr_entry == IDX_W'(e)) &&  s_wr_upper;

    // Single write has priority over the double write on its own half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_r <= '0;
        hi_r <= '0;
      end else begin
        if (hit_s_lo)   lo_r <= s_wr_data;
        else if (hit_d) lo_r <= d_wr_data[HALF_W-1:0];
        if (hit_s_hi)   hi_r <= s_wr_data;
        else if (hit_d) hi_r <= d_wr_data[2*HALF_W-1:HALF_W];
      end
    end

    assign lo_q[e] = lo_r;
    assign hi_q[e] = hi_r;
  end

  // Combinational reads: the old value is seen in the cycle of a write
  assign s_rd_data = s_rd_upper ? hi_q[s_rd_entry] : lo_q[s_rd_entry];
  assign d_rd_data = {hi_q[d_rd_entry], lo_q[d_rd_entry]};

endmodule

// File: rtl/fpr_ctrl_regs.sv
// Control space: constant revision word, writable control/status word.
module fpr_ctrl_regs
  import fpr_pkg::*;
#(
  parameter int unsigned CTRL_IDX_W = 5,
  parameter int unsigned CTRL_W     = 32,
  parameter logic [CTRL_W-1:0] REVISION = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CTRL_IDX_W-1:0] rd_idx,
  output logic [CTRL_W-1:0]     rd_data,
  input  logic                  we,
  input  logic [CTRL_IDX_W-1:0] wr_idx,
  input  logic [CTRL_W-1:0]     wr_data,
  output rnd_mode_e             rmode
);

  localparam logic [CTRL_IDX_W-1:0] REV_IDX = '0;
  localparam logic [CTRL_IDX_W-1:0] CSR_IDX = '1;

  logic [CTRL_W-1:0] csr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       csr_q <= '0;
    else if (we && wr_idx == CSR_IDX) csr_q <= wr_data;
  end

  always_comb begin
    if (rd_idx == REV_IDX)      rd_data = REVISION;
    else if (rd_idx == CSR_IDX) rd_data = csr_q;
    else                        rd_data = '0;
  end

  assign rmode = rnd_mode_e'(csr_q[RM_LSB +: 2]);

endmodule

// File: rtl/fpr_file.sv
module fpr_file
  import fpr_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned HALF_W      = 32,
  parameter int unsigned CTRL_IDX_W  = 5,
  parameter int unsigned CTRL_W      = 32,
  parameter logic [CTRL_W-1:0] REVISION = '0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fr_mode,
  input  logic [$clog2(NUM_ENTRIES)-1:0] s_rd_idx,
  output logic [HALF_W-1:0]              s_rd_data,
  input  logic [$clog2(NUM_ENTRIES)-1:0] d_rd_idx,
  output logic [2*HALF_W-1:0]            d_rd_data,
  input  logic                           s_we,
  input  logic [$clog2(NUM_ENTRIES)-1:0] s_wr_idx,
  input  logic [HALF_W-1:0]              s_wr_data,
  input  logic                           d_we,
  input  logic [$clog2(NUM_ENTRIES)-1:0] d_wr_idx,
  input  logic [2*HALF_W-1:0]            d_wr_data,
  input  logic [CTRL_IDX_W-1:0]          ctl_rd_idx,
  output logic [CTRL_W-1:0]              ctl_rd_data,
  input  logic                           ctl_we,
  input  logic [CTRL_IDX_W-1:0]          ctl_wr_idx,
  input  logic [CTRL_W-1:0]              ctl_wr_data,
  output logic [1:0]                     round_mode
);

  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);
  localparam int unsigned NPORT = 2;  // 0 = read port, 1 = write port

  // Single-view mapping for the read and the write port
  logic [IDX_W-1:0] s_idx_v   [NPORT];
  logic [IDX_W-1:0] s_entry_v [NPORT];
  logic             s_upper_v [NPORT];
  // Double-view mapping for the read and the write port
  logic [IDX_W-1:0] d_idx_v   [NPORT];
  logic [IDX_W-1:0] d_entry_v [NPORT];

  assign s_idx_v[0] = s_rd_idx;
  assign s_idx_v[1] = s_wr_idx;
  assign d_idx_v[0] = d_rd_idx;
  assign d_idx_v[1] = d_wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    fpr_slot_map #(.IDX_W(IDX_W)) u_smap (
      .fr_mode (fr_mode),
      .idx     (s_idx_v[p]),
      .entry   (s_entry_v[p]),
      .upper   (s_upper_v[p])
    );
    assign d_entry_v[p] = fr_mode ? d_idx_v[p] : {1'b0, d_idx_v[p][IDX_W-1:1]};
  end

  fpr_storage #(
    .ENTRIES (NUM_ENTRIES),
    .HALF_W  (HALF_W),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_we       (s_we),
    .s_wr_entry (s_entry_v[1]),
    .s_wr_upper (s_upper_v[1]),
    .s_wr_data  (s_wr_data),
    .d_we       (d_we),
    .d_wr_entry (d_entry_v[1]),
    .d_wr_data  (d_wr_data),
    .s_rd_entry (s_entry_v[0]),
    .s_rd_upper (s_upper_v[0]),
    .s_rd_data  (s_rd_data),
    .d_rd_entry (d_entry_v[0]),
    .d_rd_data  (d_rd_data)
  );

  rnd_mode_e rmode;

  fpr_ctrl_regs #(
    .CTRL_IDX_W (CTRL_IDX_W),
    .CTRL_W     (CTRL_W),
    .REVISION   (REVISION)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (ctl_rd_idx),
    .rd_data (ctl_rd_data),
    .we      (ctl_we),
    .wr_idx  (ctl_wr_idx),
    .wr_data (ctl_wr_data),
    .rmode   (rmode)
  );

  assign round_mode = rmode;

endmodule

// File: rtl/fpr_file_chk.sv
module fpr_file_chk #(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned HALF_W      = 32,
  parameter int unsigned CTRL_IDX_W  = 5,
  parameter int unsigned CTRL_W      = 32,
  parameter logic [CTRL_W-1:0] REVISION = '0
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           fr_mode,
  input logic [$clog2(NUM_ENTRIES)-1:0] d_rd_idx,
  input logic [2*HALF_W-1:0]            d_rd_data,
  input logic                           s_we,
  input logic [$clog2(NUM_ENTRIES)-1:0] s_wr_idx,
  input logic [HALF_W-1:0]              s_wr_data,
  input logic                           d_we,
  input logic [$clog2(NUM_ENTRIES)-1:0] d_wr_idx,
  input logic [2*HALF_W-1:0]            d_wr_data,
  input logic [CTRL_IDX_W-1:0]          ctl_rd_idx,
  input logic [CTRL_W-1:0]              ctl_rd_data,
  input logic                           ctl_we,
  input logic [CTRL_IDX_W-1:0]          ctl_wr_idx,
  input logic [CTRL_W-1:0]              ctl_wr_data,
  input logic [1:0]                     round_mode
);

  localparam logic [CTRL_IDX_W-1:0] CSR_IDX = '1;

  // R9
  rev_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_idx == '0) |-> (ctl_rd_data == REVISION));

  // R10
  rmode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wr_idx == CSR_IDX) |=> (round_mode == $past(ctl_wr_data[1:0])));

  // R8
  read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!d_we && !s_we) && (d_we || s_we) && $stable(d_rd_idx) && $stable(fr_mode))
      |-> $stable(d_rd_data));

  // R3
  dbl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_we && !s_we && d_wr_idx == d_rd_idx)
      |=> (d_rd_idx != $past(d_rd_idx) || fr_mode != $past(fr_mode) ||
           d_rd_data == $past(d_wr_data)));

  // R5
  half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && !d_we && fr_mode && s_wr_idx == d_rd_idx)
      |=> (d_rd_idx != $past(d_rd_idx) || fr_mode != $past(fr_mode) ||
           (d_rd_data[2*HALF_W-1:HALF_W] == $past(d_rd_data[2*HALF_W-1:HALF_W]) &&
            d_rd_data[HALF_W-1:0] == $past(s_wr_data))));

endmodule

bind fpr_file fpr_file_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .HALF_W      (HALF_W),
  .CTRL_IDX_W  (CTRL_IDX_W),
  .CTRL_W      (CTRL_W),
  .REVISION    (REVISION)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fr_mode     (fr_mode),
  .d_rd_idx    (d_rd_idx),
  .d_rd_data   (d_rd_data),
  .s_we        (s_we),
  .s_wr_idx    (s_wr_idx),
  .s_wr_data   (s_wr_data),
  .d_we        (d_we),
  .d_wr_idx    (d_wr_idx),
  .d_wr_data   (d_wr_data),
  .ctl_rd_idx  (ctl_rd_idx),
  .ctl_rd_data (ctl_rd_data),
  .ctl_we      (ctl_we),
  .ctl_wr_idx  (ctl_wr_idx),
  .ctl_wr_data (ctl_wr_data),
  .round_mode  (round_mode)
);

// File: tb/tb_fpr_file.sv
module tb_fpr_file;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_mode = 1'b0;
  logic [4:0]  s_rd_idx = '0;
  logic [31:0] s_rd_data;
  logic [4:0]  d_rd_idx = '0;
  logic [63:0] d_rd_data;
  logic        s_we = 1'b0;
  logic [4:0]  s_wr_idx = '0;
  logic [31:0] s_wr_data = '0;
  logic        d_we = 1'b0;
  logic [4:0]  d_wr_idx = '0;
  logic [63:0] d_wr_data = '0;
  logic [4:0]  ctl_rd_idx = '0;
  logic [31:0] ctl_rd_data;
  logic        ctl_we = 1'b0;
  logic [4:0]  ctl_wr_idx = '0;
  logic [31:0] ctl_wr_data = '0;
  logic [1:0]  round_mode;

  int n_checks = 0;
  int n_fail   = 0;

  logic [63:0] m_mem [32];
  logic [31:0] m_csr;

  always #2 clk = ~clk;

  fpr_file dut (
    .clk(clk), .rst_n(rst_n), .fr_mode(fr_mode),
    .s_rd_idx(s_rd_idx), .s_rd_data(s_rd_data),
    .d_rd_idx(d_rd_idx), .d_rd_data(d_rd_data),
    .s_we(s_we), .s_wr_idx(s_wr_idx), .s_wr_data(s_wr_data),
    .d_we(d_we), .d_wr_idx(d_wr_idx), .d_wr_data(d_wr_data),
    .ctl_rd_idx(ctl_rd_idx), .ctl_rd_data(ctl_rd_data),
    .ctl_we(ctl_we), .ctl_wr_idx(ctl_wr_idx), .ctl_wr_data(ctl_wr_data),
    .round_mode(round_mode)
  );

  function automatic logic [4:0] d_ent(input logic [4:0] i, input logic f);
    return f ? i : {1'b0, i[4:1]};
  endfunction

  function automatic logic [31:0] exp_s(input logic [4:0] i, input logic f);
    logic [63:0] w;
    w = m_mem[d_ent(i, f)];
    if (f || !i[0]) return w[31:0];
    return w[63:32];
  endfunction

  function automatic logic [31:0] exp_ctl(input logic [4:0] i);
    if (i == 5'd0)  return 32'h0;
    if (i == 5'd31) return m_csr;
    return 32'h0;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp,
                       input string tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive at the falling edge, check reads against the pre-edge model,
  // then fold the writes into the model after the rising edge.
  task automatic step(input logic f, input logic [4:0] sri, input logic [4:0] dri,
                      input logic swe, input logic [4:0] swi, input logic [31:0] swd,
                      input logic dwe, input logic [4:0] dwi, input logic [63:0] dwd,
                      input logic [4:0] cri, input logic cwe, input logic [4:0] cwi,
                      input logic [31:0] cwd, input string tag);
    logic [4:0] e;
    @(negedge clk);
    fr_mode = f; s_rd_idx = sri; d_rd_idx = dri;
    s_we = swe; s_wr_idx = swi; s_wr_data = swd;
    d_we = dwe; d_wr_idx = dwi; d_wr_data = dwd;
    ctl_rd_idx = cri; ctl_we = cwe; ctl_wr_idx = cwi; ctl_wr_data = cwd;
    #1;
    check({32'h0, s_rd_data}, {32'h0, exp_s(sri, f)}, tag, "single read");
    check(d_rd_data, m_mem[d_ent(dri, f)], tag, "double read");
    check({32'h0, ctl_rd_data}, {32'h0, exp_ctl(cri)}, tag, "control read");
    check({62'h0, round_mode}, {62'h0, m_csr[1:0]}, tag, "round mode");
    @(posedge clk);
    if (dwe) m_mem[d_ent(dwi, f)] = dwd;
    if (swe) begin
      e = d_ent(swi, f);
      if (!f && swi[0]) m_mem[e][63:32] = swd;
      else              m_mem[e][31:0]  = swd;
    end
    if (cwe && cwi == 5'd31) m_csr = cwd;
  endtask

  // Read-only step helper
  task automatic rd(input logic f, input logic [4:0] sri, input logic [4:0] dri,
                    input logic [4:0] cri, input string tag);
    step(f, sri, dri, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 64'h0, cri, 1'b0, 5'd0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] a;
    logic [4:0] b;
    logic       f;
    logic       sw;
    logic       dw;
    string      tg;
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_csr = '0;
    void'($urandom(32'd2024));

    repeat (3) @(posedge clk);
    #1;
    // R1: values held while reset is low
    check(d_rd_data, 64'h0, "R1", "double read in reset");
    check({62'h0, round_mode}, 64'h0, "R1", "round mode in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every entry and the control/status word are zero after reset
    for (int i = 0; i < 32; i++) rd(1'b1, 5'(i), 5'(i), 5'd31, "R1");

    // R2 / R3: paired mode
    step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd6, 64'hAAAA_1111_BBBB_2222,
         5'd0, 1'b0, 5'd0, 32'h0, "R3");
    rd(1'b0, 5'd6, 5'd7, 5'd0, "R2");
    rd(1'b0, 5'd7, 5'd6, 5'd0, "R2");
    rd(1'b0, 5'd7, 5'd7, 5'd0, "R3");

    // R4: wide mode
    step(1'b1, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd6, 64'hCCCC_3333_DDDD_4444,
         5'd0, 1'b0, 5'd0, 32'h0, "R4");
    rd(1'b1, 5'd6, 5'd6, 5'd0, "R4");
    rd(1'b1, 5'd7, 5'd7, 5'd0, "R4");

    // R5: single writes keep the other half
    step(1'b1, 5'd0, 5'd6, 1'b1, 5'd6, 32'h1234_5678, 1'b0, 5'd0, 64'h0,
         5'd0, 1'b0, 5'd0, 32'h0, "R5");
    rd(1'b1, 5'd6, 5'd6, 5'd0, "R5");
    step(1'b0, 5'd0, 5'd12, 1'b1, 5'd13, 32'h9ABC_DEF0, 1'b0, 5'd0, 64'h0,
         5'd0, 1'b0, 5'd0, 32'h0, "R5");
    rd(1'b0, 5'd12, 5'd13, 5'd0, "R5");

    // R6: single and double writes to one entry in one cycle
    step(1'b0, 5'd0, 5'd0, 1'b1, 5'd21, 32'hFEED_F00D, 1'b1, 5'd20, 64'h0102_0304_0506_0708,
         5'd0, 1'b0, 5'd0, 32'h0, "R6");
    rd(1'b0, 5'd21, 5'd20, 5'd0, "R6");
    step(1'b1, 5'd0, 5'd0, 1'b1, 5'd9, 32'h5555_AAAA, 1'b1, 5'd9, 64'hFFFF_FFFF_0000_0000,
         5'd0, 1'b0, 5'd0, 32'h0, "R6");
    rd(1'b1, 5'd9, 5'd9, 5'd0, "R6");

    // R7: mode change remaps without altering storage
    step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd9, 64'h7777_8888_9999_0000,
         5'd0, 1'b0, 5'd0, 32'h0, "R7");
    rd(1'b1, 5'd4, 5'd4, 5'd0, "R7");
    rd(1'b1, 5'd9, 5'd9, 5'd0, "R7");
    rd(1'b0, 5'd9, 5'd8, 5'd0, "R7");

    // R8: same-cycle read sees the old value, next cycle the new one
    step(1'b0, 5'd21, 5'd20, 1'b1, 5'd21, 32'h0BAD_CAFE, 1'b1, 5'd20, 64'h1111_2222_3333_4444,
         5'd0, 1'b0, 5'd0, 32'h0, "R8");
    rd(1'b0, 5'd21, 5'd20, 5'd0, "R8");

    // R9: control space
    step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 64'h0,
         5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, "R9");
    rd(1'b0, 5'd0, 5'd0, 5'd0, "R9");
    step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 64'h0,
         5'd5, 1'b1, 5'd5, 32'hDEAD_BEEF, "R9");
    rd(1'b0, 5'd0, 5'd0, 5'd5, "R9");
    step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 64'h0,
         5'd31, 1'b1, 5'd31, 32'hA5A5_0F0C, "R9");
    rd(1'b0, 5'd0, 5'd0, 5'd31, "R9");

    // R10: each rounding encoding
    for (int m = 1; m <= 4; m++) begin
      step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 64'h0,
           5'd31, 1'b1, 5'd31, {30'h1234, 2'(m)}, "R10");
      rd(1'b0, 5'd0, 5'd0, 5'd31, "R10");
    end

    // Random phase with a narrow index range to force collisions
    f = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 16) == 0) f = ~f;
      a  = 5'($urandom % 8);
      b  = 5'($urandom % 8);
      sw = ($urandom % 2) == 1;
      dw = ($urandom % 2) == 1;
      if (sw || dw) tg = "R8";
      else if (f)   tg = "R4";
      else          tg = "R3";
      step(f, 5'($urandom % 8), a, sw, b, $urandom, dw, 5'($urandom % 8),
           {$urandom, $urandom}, 5'($urandom), ($urandom % 4) == 0, 5'($urandom),
           $urandom, tg);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule